// File: doc/BRIEF.md
# FSK Caller-ID Transmitter

This block turns caller-ID bytes written by a host into a stream of signed audio samples carrying binary frequency-shift keying. The host pushes bytes into an eight-entry queue through a write strobe. It paces those writes by polling the empty and full flags, and it can also react to a one-cycle pulse raised when the queue drains. A sample-rate strobe (8 kHz in the system) advances the synthesis.

Each byte becomes an asynchronous character: one space start bit, eight data bits sent least significant first, and one or two mark stop bits. Every bit lasts exactly 20/3 sample periods on average, which gives 1200 baud at 8 kHz. A single phase accumulator produces the tones. Switching between mark and space changes only the phase increment, so the waveform never jumps. A select input picks between two tone pairs. A programmable number of mark bits precedes the first character of each burst. With no data the line carries a steady mark tone.

Top module: `fsk_cid_tx`

## Requirements
- R1: After reset `fifo_empty`=1, `fifo_full`=0, `tx_idle`=1, `irq_empty`=0, `sample_valid`=0 and `sample_out`=0.
- R2: The queue holds 8 bytes. `fifo_full` rises after the eighth unread write. A write while full is discarded and never transmitted. `fifo_empty` and `fifo_full` are never high together.
- R3: A character is a space start bit, then data bits 0 to 7 in that order, then mark stop bits: one when `stop2`=0, two when `stop2`=1.
- R4: Bit timing uses an accumulator that starts at 0 with each burst, adds 3 on every sample tick and closes a bit when the sum reaches 20, keeping sum-20. The first bit of a burst starts on the tick after the idle tick that found the queue non-empty.
- R5: A 16-bit phase accumulator adds one increment per tick and is not reset between bits. `spec_sel`=0 uses mark 9830 and space 18022 (1200/2200 Hz). `spec_sel`=1 uses mark 10650 and space 17203 (1300/2100 Hz).
- R6: Each sample is a triangle wave of the new phase p: f = p[14] ? ~p[13:0] : p[13:0], m = {1'b0,f,1'b0}, and the output is -m when p[15]=1, else m.
- R7: A burst starts with `lead_len` mark bits (none when 0), followed by characters back to back while the queue holds data.
- R8: With no data queued the block sends the mark tone and holds `tx_idle`=1.
- R9: `irq_empty` pulses for one cycle when removal of the last byte leaves the queue empty.
- R10: A tick with `enable`=0 yields sample 0, clears the phase and returns to idle, but keeps the queued bytes. `sample_valid` is high exactly in the cycle after each tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe per output sample |
| enable | input | 1 | Encoder enable |
| spec_sel | input | 1 | Tone pair select |
| stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| lead_len | input | 8 | Number of mark bits before a burst |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| tx_idle | output | 1 | No burst in progress |
| irq_empty | output | 1 | Pulse when queue drains |
| sample_valid | output | 1 | New sample present |
| sample_out | output | 16 | Signed sample |

## Verification
On every cycle the assertions check the handshake-level properties. These are: a valid sample follows each tick, a disabled tick yields zero and idle, a full queue stays full under a write without a tick, the drain pulse coincides with an empty queue, and the two flags exclude each other. What they cannot show is whether the tones, bit boundaries, framing order, stop count and lead-in are right. The bench's directed scenarios establish those by comparing every sample against an independent model of the bit sequence. They also show that the ninth byte is lost and that the phase restarts after a disable.

// File: rtl/fsk_cid_tx.sv
module fsk_cid_tx #(
  parameter int DEPTH      = 8,
  parameter int PH_W       = 16,
  parameter int INC_MARK0  = 9830,
  parameter int INC_SPACE0 = 18022,
  parameter int INC_MARK1  = 10650,
  parameter int INC_SPACE1 = 17203,
  parameter int BAUD_STEP  = 3,
  parameter int BAUD_MOD   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sample_tick,
  input  logic                   enable,
  input  logic                   spec_sel,
  input  logic                   stop2,
  input  logic [7:0]             lead_len,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  output logic                   fifo_empty,
  output logic                   fifo_full,
  output logic                   tx_idle,
  output logic                   irq_empty,
  output logic                   sample_valid,
  output logic signed [PH_W-1:0] sample_out
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int ACC_W = $clog2(BAUD_MOD + BAUD_STEP + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_FRAME} st_t;

  logic [7:0]      mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;
  st_t             st;
  logic [10:0]     shreg;
  logic [3:0]      nbits;
  logic [7:0]      lead_cnt;
  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0] phase;

  logic push, pop, load, cur_mark, bit_end, run;
  logic [ACC_W-1:0] acc_sum;
  logic [PH_W-1:0]  inc, ph_next, mag, wave;
  logic [PH_W-3:0]  fold;
  logic [10:0]      frame_word;
  logic [3:0]       frame_len;

  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == CW'(DEPTH));
  assign tx_idle    = (st == S_IDLE);
  assign push       = wr_en && !fifo_full;
  assign run        = sample_tick && enable;

  assign cur_mark = (st != S_FRAME) || shreg[0];
  assign acc_sum  = acc + ACC_W'(BAUD_STEP);
  assign bit_end  = (st != S_IDLE) && (acc_sum >= ACC_W'(BAUD_MOD));

  always_comb begin
    load = 1'b0;
    case (st)
      S_IDLE:  load = !fifo_empty && (lead_len == 8'd0);
      S_LEAD:  load = bit_end && (lead_cnt == 8'd1) && !fifo_empty;
      S_FRAME: load = bit_end && (nbits == 4'd1) && !fifo_empty;
      default: load = 1'b0;
    endcase
  end
  assign pop = run && load;

  assign frame_word = {2'b11, mem[rptr], 1'b0};
  assign frame_len  = stop2 ? 4'd11 : 4'd10;

  assign inc = spec_sel ? (cur_mark ? PH_W'(INC_MARK1) : PH_W'(INC_SPACE1))
                        : (cur_mark ? PH_W'(INC_MARK0) : PH_W'(INC_SPACE0));
  assign ph_next = phase + inc;
  assign fold    = ph_next[PH_W-2] ? ~ph_next[PH_W-3:0] : ph_next[PH_W-3:0];
  assign mag     = {1'b0, fold, 1'b0};
  assign wave    = ph_next[PH_W-1] ? (~mag + 1'b1) : mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= wr_data;
        wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (pop) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      shreg        <= '1;
      nbits        <= '0;
      lead_cnt     <= '0;
      acc          <= '0;
      phase        <= '0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
      irq_empty    <= 1'b0;
    end else begin
      sample_valid <= sample_tick;
      irq_empty    <= pop && (count == CW'(1)) && !push;
      if (sample_tick && !enable) begin
        st         <= S_IDLE;
        acc        <= '0;
        phase      <= '0;
        sample_out <= '0;
      end else if (run) begin
        phase      <= ph_next;
        sample_out <= wave;
        if (st != S_IDLE)
          acc <= bit_end ? acc_sum - ACC_W'(BAUD_MOD) : acc_sum;
        case (st)
          S_IDLE: if (!fifo_empty) begin
            acc <= '0;
            if (lead_len != 8'd0) begin
              st       <= S_LEAD;
              lead_cnt <= lead_len;
            end else begin
              st    <= S_FRAME;
              shreg <= frame_word;
              nbits <= frame_len;
            end
          end
          S_LEAD: if (bit_end) begin
            if (lead_cnt != 8'd1)  lead_cnt <= lead_cnt - 8'd1;
            else if (load) begin
              st    <= S_FRAME;
              shreg <= frame_word;
              nbits <= frame_len;
            end else st <= S_IDLE;
          end
          S_FRAME: if (bit_end) begin
            if (nbits != 4'd1) begin
              shreg <= {1'b1, shreg[10:1]};
              nbits <= nbits - 4'd1;
            end else if (load) begin
              shreg <= frame_word;
              nbits <= frame_len;
            end else st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_VALID_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> sample_valid); // R10
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !enable) |=> (sample_out == '0) && tx_idle); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !sample_tick) |=> fifo_full); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full)); // R2
  AST_IRQ_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> fifo_empty); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |=> !irq_empty); // R9
endmodule

// File: tb/fsk_cid_tx_test.sv
module fsk_cid_tx_test;
  logic clk = 0, rst_n = 0, sample_tick = 0, enable = 0, spec_sel = 0, stop2 = 0;
  logic [7:0] lead_len = 0, wr_data = 0;
  logic wr_en = 0;
  logic fifo_empty, fifo_full, tx_idle, irq_empty, sample_valid;
  logic signed [15:0] sample_out;

  int checks = 0, fails = 0, irq_seen = 0;
  logic [15:0] m_phase = 0;
  logic [7:0] tx_bytes [0:15];
  int bits [0:1023];

  always #2 clk = ~clk;

  fsk_cid_tx uut (.clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .enable(enable),
    .spec_sel(spec_sel), .stop2(stop2), .lead_len(lead_len), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .tx_idle(tx_idle), .irq_empty(irq_empty),
    .sample_valid(sample_valid), .sample_out(sample_out));

  always @(posedge clk) if (irq_empty) irq_seen++;

  function automatic logic [15:0] wave(input logic [15:0] p);
    logic [13:0] f;
    logic [15:0] m;
    f = p[14] ? ~p[13:0] : p[13:0];
    m = {1'b0, f, 1'b0};
    return p[15] ? -m : m;
  endfunction

  function automatic logic [15:0] incr(input bit mark, input bit spec);
    if (spec) return mark ? 16'd10650 : 16'd17203;
    return mark ? 16'd9830 : 16'd18022;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(output logic [15:0] got, output logic vld);
    @(negedge clk) sample_tick = 1;
    @(negedge clk) sample_tick = 0;
    got = sample_out; vld = sample_valid;
    @(negedge clk);
  endtask

  task automatic model_tick(input bit mark, input string rq);
    logic [15:0] got; logic vld;
    m_phase = m_phase + incr(mark, spec_sel);
    tick(got, vld);
    check(vld == 1'b1, "R10 valid", vld, 1);
    check(got == wave(m_phase), rq, got, wave(m_phase));
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) wr_en = 1; wr_data = b;
    @(negedge clk) wr_en = 0;
  endtask

  task automatic run_burst(input int nbytes, input string rq);
    int nb = 0, acc = 0, k = 0;
    for (int i = 0; i < lead_len; i++) begin bits[nb] = 1; nb++; end
    for (int j = 0; j < nbytes; j++) begin
      bits[nb] = 0; nb++;
      for (int b = 0; b < 8; b++) begin bits[nb] = tx_bytes[j][b]; nb++; end
      bits[nb] = 1; nb++;
      if (stop2) begin bits[nb] = 1; nb++; end
    end
    model_tick(1'b1, rq);
    while (k < nb) begin
      model_tick(bits[k] != 0, rq);
      acc += 3;
      if (acc >= 20) begin acc -= 20; k++; end
    end
    for (int i = 0; i < 3; i++) model_tick(1'b1, "R8 mark after burst");
  endtask

  task automatic t_reset();
    check(fifo_empty == 1 && fifo_full == 0, "R1 flags", {fifo_empty, fifo_full}, 2);
    check(tx_idle == 1 && irq_empty == 0, "R1 idle/irq", {tx_idle, irq_empty}, 2);
    check(sample_out == 0 && sample_valid == 0, "R1 sample", sample_out, 0);
  endtask

  task automatic t_fill();
    logic [7:0] v [0:8] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C, 8'h12, 8'hE7, 8'h99};
    for (int i = 0; i < 9; i++) begin
      if (i < 8) tx_bytes[i] = v[i];
      wr(v[i]);
      if (i == 6) check(fifo_full == 0, "R2 not full at 7", fifo_full, 0);
    end
    check(fifo_full == 1 && fifo_empty == 0, "R2 full at 8", fifo_full, 1);
  endtask

  task automatic t_disabled();
    logic [15:0] got; logic vld;
    for (int i = 0; i < 2; i++) begin
      tick(got, vld);
      check(got == 0 && vld == 1, "R10 disabled sample", got, 0);
    end
    check(fifo_full == 1 && tx_idle == 1, "R10 queue kept", fifo_full, 1);
    m_phase = 0;
  endtask

  task automatic t_burst_spec0();
    enable = 1; spec_sel = 0; stop2 = 0; lead_len = 3;
    run_burst(8, "R3 R4 R5 R6 R7 spec0 one stop, lead 3");
    check(fifo_empty == 1 && tx_idle == 1, "R8 idle after burst", tx_idle, 1);
    check(irq_seen == 1, "R9 one drain pulse, ninth byte dropped (R2)", irq_seen, 1);
  endtask

  task automatic t_burst_spec1();
    spec_sel = 1; stop2 = 1; lead_len = 0;
    tx_bytes[0] = 8'h6B; tx_bytes[1] = 8'h90;
    wr(8'h6B); wr(8'h90);
    run_burst(2, "R3 R4 R5 spec1 two stops, no lead (R7)");
    check(irq_seen == 2, "R9 drain pulse second burst", irq_seen, 2);
  endtask

  task automatic t_idle_mark();
    for (int i = 0; i < 5; i++) model_tick(1'b1, "R8 idle mark tone");
    check(tx_idle == 1 && irq_seen == 2, "R8 stays idle", tx_idle, 1);
  endtask

  task automatic t_phase_clear();
    logic [15:0] got; logic vld;
    enable = 0;
    tick(got, vld);
    check(got == 0, "R10 disable zero", got, 0);
    m_phase = 0; enable = 1;
    model_tick(1'b1, "R10 phase restarts from 0");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_disabled();
    t_burst_spec0();
    t_burst_spec1();
    t_idle_mark();
    t_phase_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule